// File: doc/BRIEF.md
# Reset Root-Cause Capture Unit

This block sits beside the reset controller. It watches every source that can take the chip into reset and combines them into one system-reset request. It also records in a read-only status word why the last reset happened. The sources are a power-on request, the external reset pin, brownout detectors on the battery rail and on the regulated rail, a thermal-shutdown comparator, a clock-loss detector, a software trigger and seven digital requesters: CPU reset, CPU lockup, watchdog, debug-port reset, analog sequencer timeout, analog error and digital error. The analog detectors themselves are outside the block.

Only one cause is stored. Capture is armed, and the first source to assert while it is armed is the root cause. Sources that join later are ignored. The cause is held in a pending register until every source has gone quiet. In the next cycle it is copied to the status word and capture re-arms. Any reset that appears during that copy cycle is recorded as a power-on reset. The status word is 8 bits: bits 2:0 give the main cause, bit 3 is the thermal flag, and bits 7:4 give the digital sub-cause. A 3-bit control register lets software fire a reset and enable the thermal and clock-loss sources.

The capture state machine has three states. ARMED waits for a source. HELD waits for all sources to release. COPY moves the pending cause to the status word. Its transitions are:
- arm-to-held: any source is active while ARMED; the cause is latched.
- held-stay: a source is still active while HELD.
- held-to-copy: no source is active while HELD.
- copy-to-armed: no source is active during COPY.
- copy-to-held: a source is active during COPY; the pending cause becomes power-on.

The power-on input resets the block asynchronously and leaves it in HELD with a power-on cause pending.

Top module: `rst_cause_capture`

## Requirements
- R1: While `por_i` is high, the status word and the control register read 0 and `sys_rst_o` is 1. After `por_i` is released, the status word still reads 0 (power-on).
- R2: The main-cause field, status bits 2:0, takes these codes: 0 power-on, 1 reset pin, 2 battery-rail brownout, 4 regulated-rail brownout, 6 digital reset. For any main cause other than 6, the sub-cause field (bits 7:4) is 0.
- R3: For a digital reset, bits 7:4 take these codes: 0 clock loss, 1 CPU reset (`dig_src_i[0]`), 2 lockup (`[1]`), 3 watchdog (`[2]`), 4 software, 5 debug (`[3]`), 6 analog timeout (`[4]`), E analog error (`[5]`), F digital error (`[6]`). When several digital sources start in the same cycle, the lowest code wins.
- R4: `thermal_i` has no effect unless control bit 1 is set. When it is enabled, a thermal event is recorded as main cause 1 with status bit 3 set.
- R5: `clk_loss_i` has no effect unless control bit 2 is set. When it is enabled, a clock-loss event is recorded as main cause 6 with sub-cause 0.
- R6: Writing control bit 0 as 1 produces a one-cycle reset request in the following cycle, recorded as main cause 6 with sub-cause 4. Bit 0 always reads 0, and bits 2:1 read back as written.
- R7: The root cause is the first source to assert while capture is ARMED. Sources that appear while HELD do not change the recorded cause.
- R8: When sources start in the same cycle, the priority is battery brownout, then regulated brownout, then pin or thermal, then digital.
- R9: The status word changes only at the clock edge that ends a COPY cycle. COPY follows the first HELD cycle in which no source is active, so the status stays unchanged while any source is held.
- R10: A source that is active during the COPY cycle is recorded as power-on (status 0x00) at the next copy, whatever its real cause.
- R11: `sys_rst_o` is 1 whenever any enabled source is active or the state machine is not ARMED. It falls one cycle after the COPY cycle that returns to ARMED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset request, active high, asynchronous |
| pin_rst_i | input | 1 | External reset pin request |
| bod_bat_i | input | 1 | Battery-rail brownout |
| bod_reg_i | input | 1 | Regulated-rail brownout |
| thermal_i | input | 1 | Thermal-shutdown comparator trip |
| clk_loss_i | input | 1 | Low-frequency clock loss detected |
| dig_src_i | input | 7 | Digital reset requesters, bit map as in R3 |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control write data: bit0 software reset, bit1 thermal enable, bit2 clock-loss enable |
| ctl_rdata_o | output | 3 | Control register read value |
| sys_rst_o | output | 1 | Combined system-reset request |
| status_o | output | 8 | Recorded root cause: {sub[3:0], thermal, main[2:0]} |

## Verification
The bench aims at the COPY cycle. A source injected exactly there must appear as power-on. A design that re-armed one cycle early would record the real cause instead, and one that dropped the event would return to ARMED with no record of it. It staggers sources so that a late, higher-priority brownout arrives while HELD; a design that re-evaluated priority while HELD would overwrite the first cause. It checks disabled thermal and clock-loss inputs at `sys_rst_o` and at the status word, where a missing gate would show up as a spurious reset. It also checks simultaneous digital requests, where a wrong scan direction reports the highest sub-code.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    localparam int MAIN_W  = 3;
    localparam int SUB_W   = 4;
    localparam int NUM_DIG = 7;
    localparam int NUM_SUB = NUM_DIG + 2;
    localparam int STAT_W  = SUB_W + 1 + MAIN_W;
    localparam int CTL_W   = 3;

    localparam int CLKLOSS_IDX = 0;
    localparam int SW_IDX      = 4;

    localparam int CTL_SW_BIT  = 0;
    localparam int CTL_THM_BIT = 1;
    localparam int CTL_CLK_BIT = 2;

    typedef enum logic [MAIN_W-1:0] {
        MC_POWER_ON = 3'd0,
        MC_PIN      = 3'd1,
        MC_BOD_BAT  = 3'd2,
        MC_BOD_REG  = 3'd4,
        MC_DIGITAL  = 3'd6
    } main_cause_e;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic             thermal;
        main_cause_e      main;
    } cause_t;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_HELD  = 2'd1,
        ST_COPY  = 2'd2
    } cap_state_e;

    // Slots 0..6 map straight to their code; the two error slots use E and F.
    function automatic logic [SUB_W-1:0] sub_code(input int idx);
        if (idx <= 6)
            return SUB_W'(idx);
        else if (idx == 7)
            return 4'hE;
        else
            return 4'hF;
    endfunction

endpackage

// File: rtl/rrc_ctl_reg.sv
module rrc_ctl_reg
    import rrc_pkg::*;
#(
    parameter int W = CTL_W
) (
    input  logic         clk,
    input  logic         por_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic         therm_en_o,
    output logic         clkloss_en_o,
    output logic         sw_req_o
);

    logic therm_en_q;
    logic clkloss_en_q;
    logic sw_req_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            therm_en_q   <= 1'b0;
            clkloss_en_q <= 1'b0;
            sw_req_q     <= 1'b0;
        end else begin
            sw_req_q <= we_i & wdata_i[CTL_SW_BIT];
            if (we_i) begin
                therm_en_q   <= wdata_i[CTL_THM_BIT];
                clkloss_en_q <= wdata_i[CTL_CLK_BIT];
            end
        end
    end

    always_comb begin
        rdata_o              = '0;
        rdata_o[CTL_THM_BIT] = therm_en_q;
        rdata_o[CTL_CLK_BIT] = clkloss_en_q;
    end

    assign therm_en_o   = therm_en_q;
    assign clkloss_en_o = clkloss_en_q;
    assign sw_req_o     = sw_req_q;

    // R6: a software request only follows a write that carried bit 0
    p_sw_after_write_r6: assert property (@(posedge clk) disable iff (por_i)
        sw_req_q |-> $past(we_i && wdata_i[CTL_SW_BIT]));

endmodule

// File: rtl/rrc_src_prio.sv
module rrc_src_prio
    import rrc_pkg::*;
#(
    parameter int NSUB = NUM_SUB
) (
    input  logic            bod_bat_i,
    input  logic            bod_reg_i,
    input  logic            pin_i,
    input  logic            therm_i,
    input  logic [NSUB-1:0] dig_req_i,
    output logic            any_o,
    output cause_t          cause_o
);

    logic any_dig;

    assign any_dig = |dig_req_i;
    assign any_o   = bod_bat_i | bod_reg_i | pin_i | therm_i | any_dig;

    always_comb begin
        cause_o = '0;
        if (bod_bat_i) begin
            cause_o.main = MC_BOD_BAT;
        end else if (bod_reg_i) begin
            cause_o.main = MC_BOD_REG;
        end else if (pin_i || therm_i) begin
            cause_o.main    = MC_PIN;
            cause_o.thermal = therm_i;
        end else if (any_dig) begin
            cause_o.main = MC_DIGITAL;
            // Walk downwards so the lowest active slot is the one left standing.
            for (int i = NSUB - 1; i >= 0; i--) begin
                if (dig_req_i[i])
                    cause_o.sub = sub_code(i);
            end
        end
    end

endmodule

// File: rtl/rrc_capture_fsm.sv
module rrc_capture_fsm
    import rrc_pkg::*;
(
    input  logic   clk,
    input  logic   por_i,
    input  logic   any_src_i,
    input  cause_t cause_i,
    output cause_t status_o,
    output logic   busy_o
);

    cap_state_e state_q, state_d;
    cause_t     pend_q;
    cause_t     status_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)
            state_q <= ST_HELD;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (any_src_i)  state_d = ST_HELD;
            ST_HELD:  if (!any_src_i) state_d = ST_COPY;
            ST_COPY:  state_d = any_src_i ? ST_HELD : ST_ARMED;
            default:  state_d = ST_HELD;
        endcase
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            pend_q   <= '0;
            status_q <= '0;
        end else begin
            unique case (state_q)
                ST_ARMED: if (any_src_i) pend_q <= cause_i;
                ST_COPY: begin
                    status_q <= pend_q;
                    if (any_src_i)
                        pend_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign status_o = status_q;
    assign busy_o   = (state_q != ST_ARMED);

    // R7: the first source seen while armed is latched as the pending cause
    p_capture_first_r7: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_ARMED && any_src_i) |=> (state_q == ST_HELD && pend_q == $past(cause_i)));

    // R9: no re-arm while any source is still active
    p_hold_until_release_r9: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_HELD && any_src_i) |=> (state_q == ST_HELD && $stable(pend_q)));

    // R9: the status word moves only out of a copy cycle
    p_status_on_copy_r9: assert property (@(posedge clk) disable iff (por_i)
        !$stable(status_q) |-> ($past(state_q) == ST_COPY));

    // R10: a source during the copy cycle is recorded as power-on
    p_copy_window_r10: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_COPY && any_src_i) |=> (pend_q == '0));

endmodule

// File: rtl/rst_cause_capture.sv
module rst_cause_capture
    import rrc_pkg::*;
#(
    parameter int N_DIG  = NUM_DIG,
    parameter int CW     = CTL_W,
    parameter int SW     = STAT_W
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             pin_rst_i,
    input  logic             bod_bat_i,
    input  logic             bod_reg_i,
    input  logic             thermal_i,
    input  logic             clk_loss_i,
    input  logic [N_DIG-1:0] dig_src_i,
    input  logic             ctl_we_i,
    input  logic [CW-1:0]    ctl_wdata_i,
    output logic [CW-1:0]    ctl_rdata_o,
    output logic             sys_rst_o,
    output logic [SW-1:0]    status_o
);

    localparam int NSUB = N_DIG + 2;

    logic            therm_en;
    logic            clkloss_en;
    logic            sw_req;
    logic            therm_eff;
    logic [NSUB-1:0] dig_req;
    logic            any_src;
    logic            busy;
    cause_t          cause;
    cause_t          status;

    rrc_ctl_reg #(.W(CW)) i_ctl (
        .clk          (clk),
        .por_i        (por_i),
        .we_i         (ctl_we_i),
        .wdata_i      (ctl_wdata_i),
        .rdata_o      (ctl_rdata_o),
        .therm_en_o   (therm_en),
        .clkloss_en_o (clkloss_en),
        .sw_req_o     (sw_req)
    );

    assign therm_eff = thermal_i & therm_en;

    // Slot map: clock loss first, software at its code position, the rest in order.
    for (genvar g = 0; g < NSUB; g++) begin : g_req
        if (g == CLKLOSS_IDX) begin : g_clk
            assign dig_req[g] = clk_loss_i & clkloss_en;
        end else if (g == SW_IDX) begin : g_sw
            assign dig_req[g] = sw_req;
        end else if (g < SW_IDX) begin : g_lo
            assign dig_req[g] = dig_src_i[g-1];
        end else begin : g_hi
            assign dig_req[g] = dig_src_i[g-2];
        end
    end

    rrc_src_prio #(.NSUB(NSUB)) i_prio (
        .bod_bat_i (bod_bat_i),
        .bod_reg_i (bod_reg_i),
        .pin_i     (pin_rst_i),
        .therm_i   (therm_eff),
        .dig_req_i (dig_req),
        .any_o     (any_src),
        .cause_o   (cause)
    );

    rrc_capture_fsm i_fsm (
        .clk       (clk),
        .por_i     (por_i),
        .any_src_i (any_src),
        .cause_i   (cause),
        .status_o  (status),
        .busy_o    (busy)
    );

    assign sys_rst_o = busy | any_src;
    assign status_o  = status;

    // R4: the thermal flag only ever accompanies a pin-class cause
    p_thermal_is_pin_r4: assert property (@(posedge clk) disable iff (por_i)
        status.thermal |-> (status.main == MC_PIN));

    // R2: sub-cause is zero unless the main cause is digital
    p_sub_only_digital_r2: assert property (@(posedge clk) disable iff (por_i)
        (status.main != MC_DIGITAL) |-> (status.sub == '0));

endmodule

// File: tb/test_rst_cause_capture.sv
`timescale 1ns/100ps
module test_rst_cause_capture;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       pin = 1'b0, bbat = 1'b0, breg = 1'b0, thm = 1'b0, cls = 1'b0;
    logic [6:0] dig = '0;
    logic       we = 1'b0;
    logic [2:0] wd = '0;
    logic [2:0] rd;
    logic       srst;
    logic [7:0] stat;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    rst_cause_capture i_rst_cause_capture (
        .clk         (clk),
        .por_i       (por),
        .pin_rst_i   (pin),
        .bod_bat_i   (bbat),
        .bod_reg_i   (breg),
        .thermal_i   (thm),
        .clk_loss_i  (cls),
        .dig_src_i   (dig),
        .ctl_we_i    (we),
        .ctl_wdata_i (wd),
        .ctl_rdata_o (rd),
        .sys_rst_o   (srst),
        .status_o    (stat)
    );

    // Behavioural reference: m_st 0 armed, 1 held, 2 copy
    int         m_st;
    logic [7:0] m_pend, m_stat;
    logic       m_ten, m_cen, m_sw;

    function automatic logic [8:0] ref_cause();
        logic t;
        t = thm & m_ten;
        if (bbat)                     return {1'b1, 8'h02};
        if (breg)                     return {1'b1, 8'h04};
        if (pin || t)                 return {1'b1, 4'h0, t, 3'd1};
        if (cls && m_cen)             return {1'b1, 8'h06};
        if (dig[0])                   return {1'b1, 8'h16};
        if (dig[1])                   return {1'b1, 8'h26};
        if (dig[2])                   return {1'b1, 8'h36};
        if (m_sw)                     return {1'b1, 8'h46};
        if (dig[3])                   return {1'b1, 8'h56};
        if (dig[4])                   return {1'b1, 8'h66};
        if (dig[5])                   return {1'b1, 8'hE6};
        if (dig[6])                   return {1'b1, 8'hF6};
        return 9'h000;
    endfunction

    always @(posedge clk or posedge por) begin
        if (por) begin
            m_st = 1; m_pend = 8'h00; m_stat = 8'h00;
            m_ten = 1'b0; m_cen = 1'b0; m_sw = 1'b0;
        end else begin
            logic [8:0] rc;
            rc = ref_cause();
            case (m_st)
                0: if (rc[8]) begin m_pend = rc[7:0]; m_st = 1; end
                1: if (!rc[8]) m_st = 2;
                default: begin
                    m_stat = m_pend;
                    if (rc[8]) begin m_pend = 8'h00; m_st = 1; end
                    else m_st = 0;
                end
            endcase
            m_sw = we & wd[0];
            if (we) begin m_ten = wd[1]; m_cen = wd[2]; end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [8:0] rc;
        rc = ref_cause();
        chk(32'(stat), 32'(m_stat), cur_req, "status");
        chk(32'(rd), 32'({m_cen, m_ten, 1'b0}), cur_req, "ctl");
        chk(32'(srst), 32'((m_st != 0) || rc[8]), cur_req, "sys_rst");
    endtask

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
            compare();
        end
    endtask

    task automatic wctl(input logic [2:0] v);
        we = 1'b1; wd = v;
        tick();
        we = 1'b0; wd = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(32'(stat), 0, "R1", "status in por");
        chk(32'(rd), 0, "R1", "ctl in por");
        chk(32'(srst), 1, "R1", "sys_rst in por");
        por = 1'b0;
        tick(3);
        chk(32'(stat), 0, "R1", "status after por");
        chk(32'(srst), 0, "R1", "armed after por");

        // R2: main causes
        cur_req = "R2";
        bbat = 1; tick(2); bbat = 0; tick(3);
        chk(32'(stat), 32'h02, "R2", "battery brownout");
        breg = 1; tick(2); breg = 0; tick(3);
        chk(32'(stat), 32'h04, "R2", "regulated brownout");
        pin = 1; tick(2); pin = 0; tick(3);
        chk(32'(stat), 32'h01, "R2", "pin");

        // R4: thermal gated, then enabled
        cur_req = "R4";
        thm = 1; tick(3);
        chk(32'(srst), 0, "R4", "thermal disabled no reset");
        thm = 0; tick(2);
        chk(32'(stat), 32'h01, "R4", "thermal disabled status kept");
        wctl(3'b010);
        cur_req = "R11";
        thm = 1; tick(6);
        chk(32'(srst), 1, "R11", "held while thermal");
        chk(32'(stat), 32'h01, "R9", "status held while source");
        thm = 0; tick(1);
        chk(32'(srst), 1, "R11", "copy cycle still asserted");
        tick(1);
        chk(32'(srst), 0, "R11", "released after copy");
        chk(32'(stat), 32'h09, "R4", "thermal recorded");

        // R5: clock loss gated, then enabled
        cur_req = "R5";
        cls = 1; tick(3);
        chk(32'(srst), 0, "R5", "clock loss disabled");
        cls = 0; wctl(3'b100); tick(1);
        cls = 1; tick(2); cls = 0; tick(3);
        chk(32'(stat), 32'h06, "R5", "clock loss recorded");

        // R6: software trigger
        cur_req = "R6";
        wctl(3'b111);
        chk(32'(rd), 32'b110, "R6", "bit0 reads zero");
        tick(4);
        chk(32'(stat), 32'h46, "R6", "software reset");
        wctl(3'b000);

        // R3: each digital requester alone
        cur_req = "R3";
        for (int i = 0; i < 7; i++) begin
            logic [7:0] ex;
            case (i)
                0: ex = 8'h16; 1: ex = 8'h26; 2: ex = 8'h36; 3: ex = 8'h56;
                4: ex = 8'h66; 5: ex = 8'hE6; default: ex = 8'hF6;
            endcase
            dig[i] = 1'b1; tick(2); dig = '0; tick(3);
            chk(32'(stat), 32'(ex), "R3", "digital sub-cause");
        end
        dig = 7'b1100100; tick(2); dig = '0; tick(3);
        chk(32'(stat), 32'h36, "R3", "lowest digital code wins");

        // R8: same-cycle priority
        cur_req = "R8";
        pin = 1; breg = 1; dig = 7'h01; tick(2); pin = 0; breg = 0; dig = '0; tick(3);
        chk(32'(stat), 32'h04, "R8", "regulated brownout over pin");
        bbat = 1; breg = 1; tick(2); bbat = 0; breg = 0; tick(3);
        chk(32'(stat), 32'h01 + 32'h01, "R8", "battery over regulated");
        pin = 1; dig = 7'h40; tick(2); pin = 0; dig = '0; tick(3);
        chk(32'(stat), 32'h01, "R8", "pin over digital");

        // R7: first arrival wins, later brownout ignored
        cur_req = "R7";
        dig[2] = 1; tick(2); bbat = 1; tick(2); dig = '0; bbat = 0; tick(3);
        chk(32'(stat), 32'h36, "R7", "first source kept");

        // R10: source during copy cycle becomes power-on
        cur_req = "R10";
        pin = 1; tick(1); pin = 0; tick(1);
        dig[1] = 1; tick(1); dig = '0;
        chk(32'(stat), 32'h01, "R10", "pin copied first");
        tick(3);
        chk(32'(stat), 32'h00, "R10", "copy-window event as power-on");

        // R1: power-on mid-operation clears control and status
        cur_req = "R1";
        wctl(3'b110);
        bbat = 1; tick(2); bbat = 0; tick(3);
        por = 1'b1; #1;
        chk(32'(stat), 0, "R1", "status cleared by por");
        chk(32'(rd), 0, "R1", "ctl cleared by por");
        tick(2);
        por = 1'b0;
        tick(3);
        chk(32'(srst), 0, "R1", "armed again");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule